// File: doc/BRIEF.md
# Four-Mode Bidirectional Shift Register

This block is a parameterised register of `WIDTH` stages (four by default) whose behaviour on each rising clock edge is picked by a two-bit mode input. In one mode the register keeps its contents. In another it takes a whole word from the parallel inputs. The remaining two modes move the contents one stage up or one stage down, and a serial bit fills the stage left empty. Stage 0 is the lowest stage. An up shift moves the contents toward stage `WIDTH-1`. A down shift moves them toward stage 0.

The two serial inputs let several instances act as one wider register. In up mode, wire `q_o[WIDTH-1]` of one instance to `ser_up_i` of the next. In down mode, wire `q_o[0]` of the upper instance to `ser_dn_i` of the lower one. All instances share the same clock, clear and mode. An active-low clear empties the register at once, with no clock needed, and it wins over every mode.

Top module: `ushift_reg`

## Requirements
- R1: With mode 2'b00 (hold), every stage keeps its value across the rising edge.
- R2: With mode 2'b01 (up shift), on the rising edge stage 0 takes `ser_up_i` and each stage i>0 takes the old value of stage i-1.
- R3: With mode 2'b10 (down shift), on the rising edge stage `WIDTH-1` takes `ser_dn_i` and each stage i<`WIDTH-1` takes the old value of stage i+1.
- R4: With mode 2'b11 (load), on the rising edge stage i takes `par_i[i]`, and all stages change on that same edge.
- R5: When `rst_n` goes low, all stages read 0 straight away, before any clock edge.
- R6: While `rst_n` is low, rising edges leave every stage at 0, whatever the mode and data inputs are.
- R7: After the first clear, `q_o` is all zeros.
- R8: Any data input that the current mode does not use has no effect on the next state. `par_i` is unused outside load. Both serial inputs are unused in hold and load. `ser_dn_i` is unused in up shift, and `ser_up_i` is unused in down shift.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low clear |
| mode_i | input | 2 | 00 hold, 01 up shift, 10 down shift, 11 load |
| par_i | input | WIDTH | Word loaded in mode 11; bit i goes to stage i |
| ser_up_i | input | 1 | Serial bit that enters stage 0 on an up shift |
| ser_dn_i | input | 1 | Serial bit that enters stage WIDTH-1 on a down shift |
| q_o | output | WIDTH | Stage contents, bit i is stage i |

## Verification
A wrong next-state choice in any one stage shows on `q_o` one edge later, because every stage drives the output directly. A shift fault, such as a bit taken from the wrong neighbour or the wrong serial input, keeps spreading one stage per edge until it leaves the register. A clear that does not take effect at once shows within a few nanoseconds, with no edge needed. The bench compares `q_o` with a behavioural model at every falling edge. Because the unused inputs are randomised, any leak from them shows on the first affected edge.

// File: rtl/ushift_pkg.sv
package ushift_pkg;

    typedef enum logic [1:0] {
        MD_HOLD = 2'b00,
        MD_UP   = 2'b01,
        MD_DOWN = 2'b10,
        MD_LOAD = 2'b11
    } mode_e;

    typedef struct packed {
        logic keep;
        logic up;
        logic down;
        logic load;
    } sel_t;

endpackage

// File: rtl/ushift_mode_dec.sv
module ushift_mode_dec
    import ushift_pkg::*;
(
    input  logic [1:0] mode_i,
    output sel_t       sel_o
);
    always_comb begin
        sel_o = '0;
        unique case (mode_e'(mode_i))
            MD_HOLD: sel_o.keep = 1'b1;
            MD_UP:   sel_o.up   = 1'b1;
            MD_DOWN: sel_o.down = 1'b1;
            MD_LOAD: sel_o.load = 1'b1;
            default: sel_o.keep = 1'b1;
        endcase
    end
endmodule

// File: rtl/ushift_cell.sv
module ushift_cell
    import ushift_pkg::*;
(
    input  sel_t sel_i,
    input  logic cur_i,
    input  logic below_i,
    input  logic above_i,
    input  logic par_i,
    output logic nxt_o
);
    always_comb begin
        nxt_o = cur_i;
        if (sel_i.up)        nxt_o = below_i;
        else if (sel_i.down) nxt_o = above_i;
        else if (sel_i.load) nxt_o = par_i;
    end
endmodule

// File: rtl/ushift_reg.sv
module ushift_reg
    import ushift_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       mode_i,
    input  logic [WIDTH-1:0] par_i,
    input  logic             ser_up_i,
    input  logic             ser_dn_i,
    output logic [WIDTH-1:0] q_o
);
    localparam int TOP = WIDTH - 1;

    typedef struct packed {
        logic [WIDTH-1:0] stg;
    } st_t;

    st_t              st_d, st_q;
    sel_t             sel;
    logic [WIDTH-1:0] cell_nxt;

    ushift_mode_dec u_dec (
        .mode_i (mode_i),
        .sel_o  (sel)
    );

    for (genvar i = 0; i < WIDTH; i++) begin : g_stage
        logic below_w, above_w;
        if (i == 0) begin : g_lo
            assign below_w = ser_up_i;
        end else begin : g_lo_n
            assign below_w = st_q.stg[i-1];
        end
        if (i == TOP) begin : g_hi
            assign above_w = ser_dn_i;
        end else begin : g_hi_n
            assign above_w = st_q.stg[i+1];
        end
        ushift_cell u_cell (
            .sel_i   (sel),
            .cur_i   (st_q.stg[i]),
            .below_i (below_w),
            .above_i (above_w),
            .par_i   (par_i[i]),
            .nxt_o   (cell_nxt[i])
        );
    end

    always_comb begin
        st_d     = st_q;
        st_d.stg = cell_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign q_o = st_q.stg;

    // R1
    a_r1_hold: assert property (@(posedge clk) disable iff (!rst_n)
        mode_i == 2'b00 |=> $stable(q_o));
    // R2
    a_r2_up: assert property (@(posedge clk) disable iff (!rst_n)
        mode_i == 2'b01 |=> q_o == {$past(q_o[WIDTH-2:0]), $past(ser_up_i)});
    // R3
    a_r3_down: assert property (@(posedge clk) disable iff (!rst_n)
        mode_i == 2'b10 |=> q_o == {$past(ser_dn_i), $past(q_o[WIDTH-1:1])});
    // R4
    a_r4_load: assert property (@(posedge clk) disable iff (!rst_n)
        mode_i == 2'b11 |=> q_o == $past(par_i));
    // R6
    a_r6_clear_wins: assert property (@(posedge clk)
        !rst_n |-> q_o == '0);
endmodule

// File: tb/sim_ushift_reg.sv
module sim_ushift_reg;
    localparam int W = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [1:0]   mode = 2'b00;
    logic [W-1:0] par = '0;
    logic         sup = 1'b0;
    logic         sdn = 1'b0;
    logic [W-1:0] q;

    int nchk = 0;
    int nbad = 0;
    bit done = 1'b0;
    logic [W-1:0] exp_q = '0;

    always #10 clk = ~clk;

    ushift_reg #(.WIDTH(W)) u0 (
        .clk (clk), .rst_n (rst_n), .mode_i (mode), .par_i (par),
        .ser_up_i (sup), .ser_dn_i (sdn), .q_o (q)
    );

    function automatic logic [W-1:0] model(logic [W-1:0] cur, logic [1:0] m,
                                           logic [W-1:0] p, logic u, logic d);
        logic [W-1:0] r;
        r = cur;
        case (m)
            2'b01: begin
                for (int k = W-1; k > 0; k--) r[k] = cur[k-1];
                r[0] = u;
            end
            2'b10: begin
                for (int k = 0; k < W-1; k++) r[k] = cur[k+1];
                r[W-1] = d;
            end
            2'b11: r = p;
            default: r = cur;
        endcase
        return r;
    endfunction

    function automatic string tag(logic [1:0] m);
        case (m)
            2'b00:   return "R1 hold";
            2'b01:   return "R2 up shift";
            2'b10:   return "R3 down shift";
            default: return "R4 load";
        endcase
    endfunction

    task automatic check(string req, logic [W-1:0] e);
        nchk++;
        if (q !== e) begin
            nbad++;
            $display("FAIL %s: q=%b expected %b", req, q, e);
        end
    endtask

    // Drive at falling edge, step model for the next rising edge, check at the following falling edge.
    task automatic step(logic [1:0] m, logic [W-1:0] p, logic u, logic d, string req);
        mode = m; par = p; sup = u; sdn = d;
        exp_q = model(exp_q, m, p, u, d);
        @(negedge clk);
        check(req, exp_q);
    endtask

    initial begin
        @(negedge clk);
        @(negedge clk);
        check("R7 reset state", '0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R7 after release", '0);

        step(2'b11, 4'b1011, 1'b0, 1'b0, "R4 load 1011");
        step(2'b00, 4'b0100, 1'b1, 1'b1, "R8 hold ignores data");
        step(2'b01, 4'b1111, 1'b1, 1'b0, "R2 up shift in 1");
        step(2'b01, 4'b0000, 1'b0, 1'b1, "R8 up ignores ser_dn");
        step(2'b10, 4'b1111, 1'b0, 1'b1, "R3 down shift in 1");
        step(2'b10, 4'b0000, 1'b1, 1'b0, "R8 down ignores ser_up");
        step(2'b11, 4'b0000, 1'b1, 1'b1, "R4 load zeros");
        for (int k = 0; k < W; k++) step(2'b01, 4'b1010, 1'b1, 1'b0, "R2 fill ones");
        step(2'b11, 4'b0110, 1'b0, 1'b0, "R4 load 0110");

        // clear in the middle of an up shift
        step(2'b01, 4'b0000, 1'b1, 1'b0, "R2 before clear");
        #3 rst_n = 1'b0;
        exp_q = '0;
        #2 check("R5 immediate clear", '0);
        mode = 2'b11; par = 4'b1111; sup = 1'b1; sdn = 1'b1;
        @(negedge clk);
        check("R6 clear beats load", '0);
        mode = 2'b01;
        @(negedge clk);
        check("R6 clear beats shift", '0);
        rst_n = 1'b1;
        step(2'b01, 4'b0000, 1'b1, 1'b0, "R2 after clear");

        for (int n = 0; n < 400; n++) begin
            logic [1:0] m;
            m = 2'($urandom_range(3));
            step(m, W'($urandom), 1'($urandom), 1'($urandom), tag(m));
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            nbad++;
            $display("FAIL watchdog: q=%b expected run end", q);
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
            $finish;
        end
    end
endmodule